// File: doc/BRIEF.md
# CPU Processing State Controller

This block is the sequencer that decides which of five processing states a small processor core occupies. The states are reset, exception handling, program execution, bus released and program stop. It watches an active-low reset pin, a watchdog overflow pulse, three exception request lines (trap, trace, interrupt), a bus request from a second bus master qualified by an instruction-boundary strobe, a sleep-instruction strobe and a hardware-standby level.

Exception handling is a short-lived state. The controller raises a vector-fetch request together with a code that names the exception source, and it holds both until the fetch is acknowledged. After the acknowledge, the core runs from the fetched address. A reset release, a watchdog overflow or an exit from standby takes its own path through reset into a reset vector fetch. Until that fetch completes, the interrupt-mask flag stays high.

The core and the bus fabric use the outputs as follows. The one-hot state word shows where the core is. The bus grant hands the bus to the other master. The halt output holds the core pipeline whenever the core is not executing program code.

Top module: `pstate_ctrl`

## Requirements
- R1: The state output `state_oh` is one-hot, and exactly one bit is set on every clock while `res_n` is high. The bit assignments are bit 0 reset, bit 1 exception handling, bit 2 program execution, bit 3 bus released and bit 4 program stop.
- R2: While `res_n` is low, the block is in the reset state at once, without waiting for a clock edge, and any activity in progress is abandoned. In this state `vec_req` and `bus_grant` are low and `core_halt` and `irq_mask` are high.
- R3: On the first clock edge in the reset state with `res_n` high, the block enters exception handling with `vec_src` equal to 1, the reset source code.
- R4: A `wdt_ovf` pulse sends the block from any state to the reset state on the next clock, with the grant dropped. A reset exception follows.
- R5: `irq_mask` is high in the reset state and stays high until the reset-source vector fetch is acknowledged. It is low from the clock after that acknowledge.
- R6: In exception handling, `vec_req` is high and `vec_src` holds steady until `vec_ack`. On the clock that samples `vec_ack`, the block moves to program execution. Other requests arriving during the fetch are ignored.
- R7: In program execution, a trap, trace or unmasked interrupt request moves the block to exception handling on the next clock. The source codes are trap 2, trace 3 and interrupt 4. Trap takes priority over trace, and trace over interrupt.
- R8: A bus request is granted only in program execution, only with `insn_bnd` high, and only when no exception is pending. While the bus is released, `bus_grant` is high. `core_halt` is high in every state except program execution. When `bus_req` drops, the block returns to program execution on the next clock with the grant low.
- R9: In program execution, with nothing of higher priority pending, `sleep_stb` or `hw_stby` moves the block to program stop.
- R10: In a program stop entered by sleep, an unmasked interrupt leads to exception handling with code 4. Trap and trace requests are ignored there.
- R11: In a program stop entered or continued under hardware standby, interrupts are ignored. When `hw_stby` goes low, the block moves to the reset state, and a reset exception follows.
- R12: Priority runs, from highest to lowest: reset pin, watchdog overflow, exceptions, bus request, then sleep or standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Active-low reset pin, asynchronous entry into the reset state |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| trap_req | input | 1 | Trap exception request |
| trace_req | input | 1 | Trace exception request |
| irq_req | input | 1 | Interrupt request, subject to the mask |
| bus_req | input | 1 | Bus request from the other bus master |
| insn_bnd | input | 1 | Instruction-boundary strobe |
| sleep_stb | input | 1 | Sleep instruction executed |
| hw_stby | input | 1 | Hardware standby level |
| vec_ack | input | 1 | Vector fetch acknowledge |
| vec_req | output | 1 | Vector fetch request |
| vec_src | output | CODE_W | Exception source code of the fetch |
| bus_grant | output | 1 | Bus granted to the other master |
| core_halt | output | 1 | Core halted (every state except program execution) |
| irq_mask | output | 1 | Interrupt mask flag |
| state_oh | output | 5 | One-hot processing state |

## Verification
Several corner cases are driven on purpose.

- All three exception requests arrive together, to catch an encoder that picks the wrong winner or emits the wrong code.
- A bus request arrives without the boundary strobe, which a careless design would grant mid-instruction.
- A bus request, a sleep strobe and a trap all arrive on one edge, testing the whole priority order.
- A watchdog overflow arrives while the bus is released, which a faulty design would answer by keeping the grant.

Program stop is entered both through sleep and through standby. Sleep must wake on an interrupt but not on a trap. Standby must ignore interrupts and must pass through reset on release rather than resuming. The reset pin is dropped in the middle of a vector fetch to confirm that the state changes immediately and that the next fetch carries the reset code.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

   localparam int unsigned N_STATES = 5;

   typedef enum logic [2:0] {
      PS_RST  = 3'd0,
      PS_EXC  = 3'd1,
      PS_RUN  = 3'd2,
      PS_BREL = 3'd3,
      PS_STOP = 3'd4
   } pstate_e;

   // exception source numbering; exception lines start at SRC_FIRST_EXC
   localparam int unsigned SRC_RESET     = 1;
   localparam int unsigned SRC_FIRST_EXC = 2;
   localparam int unsigned N_EXC_LINES   = 3;

endpackage

// File: rtl/pstate_pick.sv
module pstate_pick #(
   parameter int unsigned N_SRC     = 3,
   parameter int unsigned CODE_W    = 3,
   parameter int unsigned CODE_BASE = 2
) (
   input  logic [N_SRC-1:0]  req,
   output logic              valid,
   output logic [CODE_W-1:0] code
);

   if (CODE_BASE + N_SRC > (1 << CODE_W)) begin : g_range_bad
      $error("pstate_pick: CODE_W too narrow for the source codes");
   end

   // index 0 wins: scan from the lowest priority up so the last hit stands
   always_comb begin
      valid = |req;
      code  = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (req[i]) code = CODE_W'(CODE_BASE + i);
      end
   end

endmodule

// File: rtl/pstate_next.sv
module pstate_next
   import pstate_pkg::*;
#(
   parameter int unsigned CODE_W = 3
) (
   input  pstate_e           cur,
   input  logic              stby_q,
   input  logic              wdt,
   input  logic              exc_v,
   input  logic [CODE_W-1:0] exc_code,
   input  logic              irq_ok,
   input  logic              breq,
   input  logic              ibnd,
   input  logic              slp,
   input  logic              stby,
   input  logic              ack,
   output pstate_e           nxt,
   output logic              src_ld,
   output logic [CODE_W-1:0] nsrc,
   output logic              nstby
);

   localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(SRC_RESET);
   localparam logic [CODE_W-1:0] IRQ_CODE = CODE_W'(SRC_FIRST_EXC + N_EXC_LINES - 1);

   always_comb begin
      nxt    = cur;
      src_ld = 1'b0;
      nsrc   = exc_code;
      nstby  = stby_q;
      case (cur)
         PS_RST: begin
            nxt    = PS_EXC;
            src_ld = 1'b1;
            nsrc   = RST_CODE;
            nstby  = 1'b0;
         end
         PS_EXC: begin
            if (ack) nxt = PS_RUN;
         end
         PS_RUN: begin
            if (exc_v) begin
               nxt    = PS_EXC;
               src_ld = 1'b1;
            end else if (breq && ibnd) begin
               nxt = PS_BREL;
            end else if (slp || stby) begin
               nxt   = PS_STOP;
               nstby = stby;
            end
         end
         PS_BREL: begin
            if (!breq) nxt = PS_RUN;
         end
         PS_STOP: begin
            if (stby_q) begin
               if (!stby) nxt = PS_RST;
            end else if (stby) begin
               nstby = 1'b1;
            end else if (irq_ok) begin
               nxt    = PS_EXC;
               src_ld = 1'b1;
               nsrc   = IRQ_CODE;
            end
         end
         default: nxt = PS_RST;
      endcase
      if (wdt) begin
         nxt    = PS_RST;
         src_ld = 1'b0;
         nstby  = 1'b0;
      end
   end

endmodule

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
   import pstate_pkg::*;
#(
   parameter int unsigned CODE_W     = 3,
   parameter bit          ONEHOT_REG = 1'b0
) (
   input  logic                clk,
   input  logic                res_n,
   input  logic                wdt_ovf,
   input  logic                trap_req,
   input  logic                trace_req,
   input  logic                irq_req,
   input  logic                bus_req,
   input  logic                insn_bnd,
   input  logic                sleep_stb,
   input  logic                hw_stby,
   input  logic                vec_ack,
   output logic                vec_req,
   output logic [CODE_W-1:0]   vec_src,
   output logic                bus_grant,
   output logic                core_halt,
   output logic                irq_mask,
   output logic [N_STATES-1:0] state_oh
);

   localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(SRC_RESET);

   if (CODE_W < 3) begin : g_width_bad
      $error("pstate_ctrl: CODE_W must be at least 3");
   end

   pstate_e           state_q, nxt;
   logic [CODE_W-1:0] src_q, nsrc, exc_code;
   logic              stby_q, nstby, src_ld, exc_v, mask_q, irq_ok;

   assign irq_ok = irq_req & ~mask_q;

   pstate_pick #(
      .N_SRC    (N_EXC_LINES),
      .CODE_W   (CODE_W),
      .CODE_BASE(SRC_FIRST_EXC)
   ) u_pick (
      .req  ({irq_ok, trace_req, trap_req}),
      .valid(exc_v),
      .code (exc_code)
   );

   pstate_next #(.CODE_W(CODE_W)) u_next (
      .cur     (state_q),
      .stby_q  (stby_q),
      .wdt     (wdt_ovf),
      .exc_v   (exc_v),
      .exc_code(exc_code),
      .irq_ok  (irq_ok),
      .breq    (bus_req),
      .ibnd    (insn_bnd),
      .slp     (sleep_stb),
      .stby    (hw_stby),
      .ack     (vec_ack),
      .nxt     (nxt),
      .src_ld  (src_ld),
      .nsrc    (nsrc),
      .nstby   (nstby)
   );

   always_ff @(posedge clk or negedge res_n) begin
      if (!res_n) begin
         state_q <= PS_RST;
         src_q   <= RST_CODE;
         stby_q  <= 1'b0;
         mask_q  <= 1'b1;
      end else begin
         state_q <= nxt;
         stby_q  <= nstby;
         if (src_ld) src_q <= nsrc;
         if (nxt == PS_RST)
            mask_q <= 1'b1;
         else if (state_q == PS_EXC && vec_ack && src_q == RST_CODE)
            mask_q <= 1'b0;
      end
   end

   assign vec_req   = (state_q == PS_EXC);
   assign vec_src   = src_q;
   assign bus_grant = (state_q == PS_BREL);
   assign core_halt = (state_q != PS_RUN);
   assign irq_mask  = mask_q;

   for (genvar k = 0; k < N_STATES; k++) begin : g_bit
      if (ONEHOT_REG) begin : g_ff
         logic oh_q;
         always_ff @(posedge clk or negedge res_n) begin
            if (!res_n) oh_q <= (k == 0);
            else        oh_q <= (nxt == pstate_e'(3'(k)));
         end
         assign state_oh[k] = oh_q;
      end else begin : g_dec
         assign state_oh[k] = (state_q == pstate_e'(3'(k)));
      end
   end

endmodule

// File: rtl/pstate_chk.sv
module pstate_chk #(
   parameter int unsigned CODE_W = 3
) (
   input logic              clk,
   input logic              res_n,
   input logic              wdt_ovf,
   input logic              bus_req,
   input logic              vec_ack,
   input logic              vec_req,
   input logic [CODE_W-1:0] vec_src,
   input logic              bus_grant,
   input logic              core_halt,
   input logic              irq_mask,
   input logic [4:0]        state_oh
);

   // R1
   state_onehot_chk: assert property (@(posedge clk) disable iff (!res_n)
      $countones(state_oh) == 1);

   // R3
   reset_exc_chk: assert property (@(posedge clk) disable iff (!res_n)
      state_oh[0] && !wdt_ovf |=> vec_req && vec_src == CODE_W'(1));

   // R4
   wdt_reset_chk: assert property (@(posedge clk) disable iff (!res_n)
      wdt_ovf |=> state_oh[0] && !bus_grant);

   // R5
   mask_in_reset_chk: assert property (@(posedge clk) disable iff (!res_n)
      state_oh[0] |-> irq_mask);

   // R6
   vec_hold_chk: assert property (@(posedge clk) disable iff (!res_n)
      vec_req && !vec_ack && !wdt_ovf |=> vec_req && $stable(vec_src));

   // R6
   vec_done_chk: assert property (@(posedge clk) disable iff (!res_n)
      vec_req && vec_ack && !wdt_ovf |=> state_oh[2]);

   // R8
   grant_halt_chk: assert property (@(posedge clk) disable iff (!res_n)
      bus_grant |-> core_halt);

   // R8
   grant_drop_chk: assert property (@(posedge clk) disable iff (!res_n)
      bus_grant && !bus_req && !wdt_ovf |=> !bus_grant && state_oh[2]);

endmodule

bind pstate_ctrl pstate_chk #(.CODE_W(CODE_W)) u_pstate_chk (
   .clk      (clk),
   .res_n    (res_n),
   .wdt_ovf  (wdt_ovf),
   .bus_req  (bus_req),
   .vec_ack  (vec_ack),
   .vec_req  (vec_req),
   .vec_src  (vec_src),
   .bus_grant(bus_grant),
   .core_halt(core_halt),
   .irq_mask (irq_mask),
   .state_oh (state_oh)
);

// File: tb/pstate_ctrl_bench.sv
module pstate_ctrl_bench;

   localparam int unsigned NV = 29;
   localparam logic [4:0] S_RST = 5'b00001, S_EXC = 5'b00010, S_RUN = 5'b00100,
                          S_BRL = 5'b01000, S_STP = 5'b10000;

   // inputs: {wdt, trap, trace, irq, breq, ibnd, sleep, stby, ack}
   // row:    {inputs, expected state_oh, expected vec_src (exception only), expected mask}
   localparam logic [17:0] VEC [NV] = '{
      {9'b000000000, S_EXC, 3'd1, 1'b1},  // R3 reset exception
      {9'b000100000, S_EXC, 3'd1, 1'b1},  // R5 mask held during fetch
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R6 R5 ack clears mask
      {9'b011100000, S_EXC, 3'd2, 1'b0},  // R7 trap wins
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R6
      {9'b001100000, S_EXC, 3'd3, 1'b0},  // R7 trace over irq
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R6
      {9'b000100000, S_EXC, 3'd4, 1'b0},  // R7 irq
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R6
      {9'b000010000, S_RUN, 3'd0, 1'b0},  // R8 no boundary, no grant
      {9'b000011000, S_BRL, 3'd0, 1'b0},  // R8 grant
      {9'b000110000, S_BRL, 3'd0, 1'b0},  // R8 held
      {9'b000000000, S_RUN, 3'd0, 1'b0},  // R8 release
      {9'b000011100, S_BRL, 3'd0, 1'b0},  // R12 bus over sleep
      {9'b000000000, S_RUN, 3'd0, 1'b0},  // R8
      {9'b000000100, S_STP, 3'd0, 1'b0},  // R9 sleep
      {9'b010000000, S_STP, 3'd0, 1'b0},  // R10 trap ignored
      {9'b000100000, S_EXC, 3'd4, 1'b0},  // R10 irq wakes
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R6
      {9'b000000010, S_STP, 3'd0, 1'b0},  // R9 standby
      {9'b000100010, S_STP, 3'd0, 1'b0},  // R11 irq ignored
      {9'b000000000, S_RST, 3'd0, 1'b1},  // R11 release to reset
      {9'b000000000, S_EXC, 3'd1, 1'b1},  // R11 reset exception
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R5
      {9'b110000000, S_RST, 3'd0, 1'b1},  // R4 R12 watchdog over trap
      {9'b000000000, S_EXC, 3'd1, 1'b1},  // R4
      {9'b000000001, S_RUN, 3'd0, 1'b0},  // R6
      {9'b010011100, S_EXC, 3'd2, 1'b0},  // R12 exception over bus
      {9'b000000001, S_RUN, 3'd0, 1'b0}   // R6
   };
   localparam int unsigned TAG [NV] = '{3,5,6,7,6,7,6,7,6,8,8,8,8,12,8,9,10,10,6,9,11,11,11,5,4,4,6,12,6};

   logic clk = 1'b0;
   logic res_n = 1'b0;
   logic wdt_ovf = 1'b0, trap_req = 1'b0, trace_req = 1'b0, irq_req = 1'b0;
   logic bus_req = 1'b0, insn_bnd = 1'b0, sleep_stb = 1'b0, hw_stby = 1'b0, vec_ack = 1'b0;
   logic vec_req, bus_grant, core_halt, irq_mask;
   logic [2:0] vec_src;
   logic [4:0] state_oh;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pstate_ctrl u_pstate_ctrl (
      .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .trap_req(trap_req),
      .trace_req(trace_req), .irq_req(irq_req), .bus_req(bus_req),
      .insn_bnd(insn_bnd), .sleep_stb(sleep_stb), .hw_stby(hw_stby),
      .vec_ack(vec_ack), .vec_req(vec_req), .vec_src(vec_src),
      .bus_grant(bus_grant), .core_halt(core_halt), .irq_mask(irq_mask),
      .state_oh(state_oh)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [8:0] v);
      @(negedge clk);
      {wdt_ovf, trap_req, trace_req, irq_req, bus_req, insn_bnd, sleep_stb, hw_stby, vec_ack} = v;
      @(posedge clk);
      #1;
   endtask

   // expected side outputs follow from the state: R6 vec_req, R8 grant and halt
   task automatic chk_state(input string tag, input logic [4:0] oh, input logic [2:0] src,
                            input logic msk);
      chk({tag, " state"}, {27'd0, state_oh}, {27'd0, oh});
      chk({tag, " R1 onehot"}, {31'd0, $countones(state_oh) == 1}, 32'd1);
      chk({tag, " mask"}, {31'd0, irq_mask}, {31'd0, msk});
      chk({tag, " outs"}, {29'd0, vec_req, bus_grant, core_halt},
          {29'd0, oh == S_EXC, oh == S_BRL, oh != S_RUN});
      if (oh == S_EXC) chk({tag, " src"}, {29'd0, vec_src}, {29'd0, src});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk_state("R2 reset held", S_RST, 3'd0, 1'b1);
      @(negedge clk);
      res_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][17:9]);
         chk_state($sformatf("R%0d row%0d", TAG[i], i), VEC[i][8:4], VEC[i][3:1], VEC[i][0]);
      end

      // R4 watchdog while bus released drops the grant
      step(9'b000011000);
      chk_state("R8 grant again", S_BRL, 3'd0, 1'b0);
      step(9'b100010000);
      chk_state("R4 wdt in bus released", S_RST, 3'd0, 1'b1);
      step(9'b000000000);
      chk_state("R4 then reset fetch", S_EXC, 3'd1, 1'b1);
      // R6 source held across unacknowledged cycles
      step(9'b011100000);
      chk_state("R6 hold 1", S_EXC, 3'd1, 1'b1);
      step(9'b001000000);
      chk_state("R6 hold 2", S_EXC, 3'd1, 1'b1);
      step(9'b000000001);
      chk_state("R6 ack", S_RUN, 3'd0, 1'b0);

      // R2 reset pin mid-fetch acts without a clock edge
      step(9'b010000000);
      chk_state("R7 trap", S_EXC, 3'd2, 1'b0);
      @(negedge clk);
      {wdt_ovf, trap_req, trace_req, irq_req, bus_req, insn_bnd, sleep_stb, hw_stby, vec_ack} = '0;
      res_n = 1'b0;
      #1;
      chk_state("R2 async entry", S_RST, 3'd0, 1'b1);
      @(negedge clk);
      res_n = 1'b1;
      step(9'b000000000);
      chk_state("R3 after pin release", S_EXC, 3'd1, 1'b1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired R1 actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule